// File: doc/BRIEF.md
# Serial Channel Status and Interrupt Identification

This block keeps the status of one serial channel and decides whether that channel requests an interrupt. It brings the three modem inputs (clear-to-send, data-set-ready, carrier detect) into the clock domain through two-flop synchronizers. It reports the live transmit and receive conditions. It also holds receive events as sticky flags until the host collects them.

The host sees two values. The first is a 16-bit status word. Its low byte is live. Its high byte holds sticky event flags, which a full-word read clears, plus one mode bit that the host can write. The second is an 8-bit interrupt identification byte, which lists every pending cause. A set of per-cause enables gates these causes into a single interrupt line.

The UART datapath, the FIFOs and the bus decoder live outside this block. They reach it as level flags and one-cycle strobes.

Top module: `serial_status_unit`

## Requirements
- R1: After reset, `stat_word` bits 15..3 and `id_byte` bits 3..0 are 0. With all inputs low, `irq` and `tx_drained` are 0.
- R2: The low status byte is live. Bit 0 = `rx_avail`, bit 1 = `txsh_empty` and bit 2 = `txf_empty`, all in the same cycle. Bit 3 = CD, bit 4 = DSR and bit 5 = CTS, each showing its pin value after the second rising edge that follows a change. Bits 7..6 and 14 read 0.
- R3: A one-cycle pulse on `rx_evt[i]` sets status bit 8+i from the next cycle on, and the bit holds. The `rx_evt` bits are: 0 parity error, 1 framing error, 2 break, 3 compare-byte-1 match, 4 compare-byte-2 match, 5 receive overflow.
- R4: A pulse on `rd_word` clears status bits 13..8 at the next edge. An `rx_evt` bit that arrives in the same cycle as the read stays set.
- R5: A pulse on `rd_low` alone leaves bits 13..8 unchanged.
- R6: A pulse on `wr_word` loads `wr_mode` into status bit 15. Reads do not change bit 15.
- R7: In the ID byte, bit 5 = `rx_trig` and bit 4 = `txf_empty`, both live. Bit 3 is the OR of the break, framing and parity sticky flags.
- R8: ID bit 2 (CD), bit 1 (CTS) and bit 0 (DSR) are set by either edge of the synchronized pin, three rising edges after the pin changes. A pulse on `rd_id` clears them at the next edge. An edge that arrives in the same cycle as the read still sets its flag.
- R9: The enables are `irq_en` bit 0 for modem change (ID bits 2..0), bit 1 for the receive trigger (ID bit 5), bit 2 for the special receive condition (ID bit 3) and bit 3 for transmit FIFO empty (ID bit 4). `irq` is high exactly when some ID cause is set and its enable is set. A cause still appears in `id_byte` when its enable is off.
- R10: `tx_drained` is 1 exactly when `txf_empty` and `txsh_empty` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cts_pin | input | 1 | Clear-to-send pin, asynchronous |
| dsr_pin | input | 1 | Data-set-ready pin, asynchronous |
| cd_pin | input | 1 | Carrier-detect pin, asynchronous |
| txf_empty | input | 1 | Transmit FIFO is empty |
| txsh_empty | input | 1 | Transmit shift register is empty |
| rx_avail | input | 1 | Receive data is available |
| rx_trig | input | 1 | Receive FIFO has reached its trigger level |
| rx_evt | input | 6 | One-cycle receive event strobes |
| rd_word | input | 1 | 16-bit read of the status word |
| rd_low | input | 1 | Byte read of the low status half |
| wr_word | input | 1 | Write strobe for the status word |
| wr_mode | input | 1 | Value written to the mode bit |
| rd_id | input | 1 | Read of the interrupt ID byte |
| irq_en | input | 4 | Per-cause interrupt enables |
| stat_word | output | 16 | Status word |
| id_byte | output | 8 | Interrupt identification byte |
| tx_drained | output | 1 | Transmitter fully drained |
| irq | output | 1 | Interrupt request |

## Verification
The hardest cases are the collisions: a clearing read that lands in the same cycle as a new event, or a modem-change edge that lands in the same cycle as a read of the ID byte. If the block gets either wrong, the event is lost without trace.

For the modem case, the bench changes a pin at a counted distance before the ID read, so that the edge-detect cycle meets the read strobe exactly. It then checks that the change flag is still set afterwards. For the status word, the bench pulses a read and an event strobe together, then checks that only that event's bit is still set.

// File: rtl/serial_status_unit.sv
module serial_status_unit (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cts_pin,
  input  logic        dsr_pin,
  input  logic        cd_pin,
  input  logic        txf_empty,
  input  logic        txsh_empty,
  input  logic        rx_avail,
  input  logic        rx_trig,
  input  logic [5:0]  rx_evt,
  input  logic        rd_word,
  input  logic        rd_low,
  input  logic        wr_word,
  input  logic        wr_mode,
  input  logic        rd_id,
  input  logic [3:0]  irq_en,
  output logic [15:0] stat_word,
  output logic [7:0]  id_byte,
  output logic        tx_drained,
  output logic        irq
);

  // modem vector order {cd, cts, dsr} matches ID bits 2..0
  logic [2:0] mdm_s1, mdm_s2, mdm_prev, mdm_dlt;
  logic [5:0] evt_q;
  logic       mode_q;
  logic [2:0] mdm_edge;
  logic       src_cond;

  assign mdm_edge = mdm_s2 ^ mdm_prev;
  assign src_cond = |evt_q[2:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mdm_s1   <= '0;
      mdm_s2   <= '0;
      mdm_prev <= '0;
      mdm_dlt  <= '0;
      evt_q    <= '0;
      mode_q   <= 1'b0;
    end else begin
      mdm_s1   <= {cd_pin, cts_pin, dsr_pin};
      mdm_s2   <= mdm_s1;
      mdm_prev <= mdm_s2;
      mdm_dlt  <= (rd_id ? 3'b000 : mdm_dlt) | mdm_edge;
      evt_q    <= (rd_word ? 6'b000000 : evt_q) | rx_evt;
      if (wr_word) mode_q <= wr_mode;
    end
  end

  assign stat_word = {mode_q, 1'b0, evt_q, 2'b00,
                      mdm_s2[1], mdm_s2[0], mdm_s2[2],
                      txf_empty, txsh_empty, rx_avail};
  assign id_byte    = {2'b00, rx_trig, txf_empty, src_cond, mdm_dlt};
  assign tx_drained = txf_empty & txsh_empty;
  assign irq = (irq_en[0] & |id_byte[2:0]) | (irq_en[1] & id_byte[5]) |
               (irq_en[2] & id_byte[3])   | (irq_en[3] & id_byte[4]);

  a_r3_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
    rx_evt[2] |=> stat_word[10]);
  a_r4_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_word && rx_evt == 6'b0) |=> stat_word[13:8] == 6'b0);
  a_r5_low_read_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_low && !rd_word) |=> (stat_word[13:8] & $past(stat_word[13:8])) == $past(stat_word[13:8]));
  a_r6_mode_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_word |=> $stable(stat_word[15]));
  a_r8_id_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_id && mdm_edge == 3'b0) |=> id_byte[2:0] == 3'b0);
  a_r9_special_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_evt[0] && irq_en[2]) |=> irq);

endmodule

// File: tb/serial_status_unit_tb_top.sv
module serial_status_unit_tb_top;
  logic clk = 0, rst_n = 0;
  logic cts_pin = 0, dsr_pin = 0, cd_pin = 0;
  logic txf_empty = 0, txsh_empty = 0, rx_avail = 0, rx_trig = 0;
  logic [5:0] rx_evt = 0;
  logic rd_word = 0, rd_low = 0, wr_word = 0, wr_mode = 0, rd_id = 0;
  logic [3:0] irq_en = 0;
  logic [15:0] stat_word;
  logic [7:0] id_byte;
  logic tx_drained, irq;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  serial_status_unit dut_i (.*);

  // {irq_en, rx_trig txf txsh rxa, exp irq drained id5 id4 s2 s1 s0}
  localparam logic [14:0] VEC [8] = '{
    {4'b0000, 4'b0001, 7'b0000001},
    {4'b0000, 4'b0110, 7'b0101110},
    {4'b1000, 4'b0100, 7'b1001100},
    {4'b0010, 4'b1000, 7'b1010000},
    {4'b0101, 4'b1010, 7'b0010010},
    {4'b1111, 4'b1111, 7'b1111111},
    {4'b1010, 4'b0011, 7'b0000011},
    {4'b0111, 4'b0100, 7'b0001100}};

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    step(2);
    chk("R1 reset stat", {16'(stat_word[15:3])}, 0);
    chk("R1 reset id", {28'(0), id_byte[3:0]}, 0);
    chk("R1 reset irq/drained", {irq, tx_drained}, 0);
    rst_n = 1;
    step();
    foreach (VEC[i]) begin
      {irq_en, rx_trig, txf_empty, txsh_empty, rx_avail} = VEC[i][14:7];
      #1;
      chk("R2/R7/R9/R10 table", {irq, tx_drained, id_byte[5:4], stat_word[2:0]}, VEC[i][6:0]);
      step();
    end
    {irq_en, rx_trig, txf_empty, txsh_empty, rx_avail} = 0;
    // R3 sticky set and hold
    rx_evt = 6'b100100; step(); rx_evt = 0;
    chk("R3 set", stat_word[13:8], 6'b100100);
    step(3);
    chk("R3 hold", stat_word[13:8], 6'b100100);
    chk("R7 special cond", id_byte[3], 1);
    // R5 low read
    rd_low = 1; step(); rd_low = 0;
    chk("R5 low read keeps", stat_word[13:8], 6'b100100);
    // R4 read clears
    rd_word = 1; step(); rd_word = 0;
    chk("R4 clear", stat_word[13:8], 0);
    chk("R7 special gone", id_byte[3], 0);
    // R4 collision
    rx_evt = 6'b001000; step(); rx_evt = 6'b000001; rd_word = 1; step();
    rx_evt = 0; rd_word = 0;
    chk("R4 collide keeps new", stat_word[13:8], 6'b000001);
    // R9 special enable
    irq_en = 4'b0100; #1;
    chk("R9 special irq", irq, 1);
    irq_en = 4'b0011; #1;
    chk("R9 disabled but visible", {irq, id_byte[3]}, 2'b01);
    rd_word = 1; step(); rd_word = 0; irq_en = 0;
    // R6 mode
    wr_word = 1; wr_mode = 1; step(); wr_word = 0; wr_mode = 0;
    chk("R6 mode set", stat_word[15], 1);
    rd_word = 1; rd_low = 1; step(); rd_word = 0; rd_low = 0;
    chk("R6 mode kept", {stat_word[15], stat_word[14]}, 2'b10);
    wr_word = 1; step(); wr_word = 0;
    chk("R6 mode clear", stat_word[15], 0);
    // R2/R8 modem CTS rise
    cts_pin = 1; step();
    chk("R2 cts not yet", stat_word[5], 0);
    step();
    chk("R2 cts visible", stat_word[5:3], 3'b100);
    chk("R8 delta not yet", id_byte[1], 0);
    step();
    chk("R8 cts delta", id_byte[2:0], 3'b010);
    irq_en = 4'b0001; #1;
    chk("R9 modem irq", irq, 1);
    rd_id = 1; step(); rd_id = 0;
    chk("R8 cleared", id_byte[2:0], 0);
    chk("R9 irq drop", irq, 0);
    // R8 falling edge on DSR and CD rise
    dsr_pin = 1; cd_pin = 1; step(3);
    chk("R2 dsr cd", stat_word[5:3], 3'b111);
    chk("R8 dsr cd delta", id_byte[2:0], 3'b101);
    rd_id = 1; step(); rd_id = 0;
    dsr_pin = 0; step(3);
    chk("R8 falling edge", id_byte[2:0], 3'b001);
    rd_id = 1; step(); rd_id = 0;
    // R8 collision: edge detected in the read cycle
    cd_pin = 0; step(2); rd_id = 1; step(); rd_id = 0;
    chk("R8 collide keeps", id_byte[2:0], 3'b100);
    rd_id = 1; step(); rd_id = 0;
    chk("R8 final clear", id_byte[2:0], 0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule